// File: doc/BRIEF.md
# Periodic Interrupt Entry Sequencer

This block raises a periodic interrupt according to an arithmetic schedule measured in retired instructions, and works out the processor-state update that entering that interrupt requires. A retire strobe marks each instruction boundary. The block counts these strobes. At each boundary it decides whether the schedule fires and whether the interrupt is masked, using the status word and program counter that the finished instruction left behind. When the interrupt is taken, it presents the following values for the register file to apply:

- the new status word;
- the copy of the old status word that goes to the banked saved-status register;
- the banked link value;
- the vector address.

The interrupt has two flavours, chosen by configuration: a fast interrupt and a normal interrupt. They differ in three ways: which mask bit gates them, which mode they enter, and where they vector. The schedule is set by a start cycle, an offset and a period. The configuration is expected to be set before reset is released and held until the next reset.

Top module: `tick_irq_entry`

## Requirements
- R1: `retired_cnt` is 0 after reset. It rises by exactly one in the clock edge that samples `retire` high, and holds otherwise.
- R2: Let base = `cfg_start` + `cfg_offset`, and let c be the count value reached by a retire. That retire fires the schedule when c >= base and (c - base - 1) mod `cfg_period` == 0. Read modulo the period, this means: with a period of 1, every c >= base fires; with a larger period, the first firing is at c = base + 1.
- R3: While `cfg_en` is low, or while `cfg_period` is 0, `take` never rises.
- R4: A fast interrupt (`cfg_fast` = 1) is taken only if bit 6 of `cur_status` (fast mask) is 0.
- R5: A normal interrupt (`cfg_fast` = 0) is taken only if bit 7 of `cur_status` (normal mask) is 0 and the mode field `cur_status[4:0]` is not the fast mode code 5'h11.
- R6: A taken interrupt shows as `take` high for exactly the one cycle after the retiring edge. The decision uses the `cur_status` and `cur_pc` presented together with that retire.
- R7: When `take` is high, `saved_status` equals the `cur_status` presented with the retire.
- R8: When `take` is high, `new_status` equals the old status word with four changes:
  - bits [4:0] become 5'h11 (fast) or 5'h12 (normal);
  - bit 7 is set;
  - bit 6 is set on fast entry and keeps its old value on normal entry;
  - all other bits are unchanged.
- R9: When `take` is high, `link_val` equals the retiring `cur_pc` minus 4.
- R10: When `take` is high, `vector_pc` is 32'h24 for fast entry and 32'h20 for normal entry. These are the vectors 0x1C and 0x18 plus the 8-byte prefetch offset.
- R11: `take` never rises in a cycle that did not follow a retire, whatever the status word shows in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire | input | 1 | One instruction finished in this cycle |
| cfg_en | input | 1 | Schedule enable |
| cfg_fast | input | 1 | 1 selects the fast interrupt, 0 the normal one |
| cfg_start | input | 32 | Start cycle of the schedule |
| cfg_offset | input | 32 | Offset added to the start cycle |
| cfg_period | input | 32 | Period in retired instructions; 0 disables |
| cur_status | input | 32 | Status word after the retiring instruction |
| cur_pc | input | 32 | Program counter register after the retiring instruction |
| retired_cnt | output | 32 | Retired-instruction count |
| take | output | 1 | Interrupt entry pulse |
| new_status | output | 32 | Status word to install on entry |
| saved_status | output | 32 | Value for the banked saved-status register |
| link_val | output | 32 | Value for the banked link register |
| vector_pc | output | 32 | Program counter to load on entry |

## Verification
The bench builds the block with its default parameters:
- 32-bit counter, address and status widths;
- mask bits at 6 and 7;
- mode codes 5'h11 and 5'h12;
- vectors 0x18 and 0x1C with an 8-byte prefetch offset.

With these values, small start, offset and period settings make the schedule's edge cases reachable within a few dozen retires:
- a base of zero;
- a period of one;
- the first firing one count past the base;
- consecutive firings on back-to-back retires.

Random status words are drawn with the mode field picked from a set that includes the fast mode code, so that both masking paths are exercised.

// File: rtl/tie_pkg.sv
package tie_pkg;

   // flavour of the scheduled interrupt
   typedef enum logic {
      KIND_NORMAL = 1'b0,
      KIND_FAST   = 1'b1
   } tie_kind_e;

endpackage

// File: rtl/tie_sched.sv
// Retire counter plus phase tracker that evaluates the arithmetic schedule
// without a divider: phase holds (count - base) mod period once count >= base.
module tie_sched #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             retire,
   input  logic             en,
   input  logic [CNT_W-1:0] start,
   input  logic [CNT_W-1:0] offset,
   input  logic [CNT_W-1:0] period,
   output logic [CNT_W-1:0] cnt,
   output logic             hit
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] ph_q;
   logic [CNT_W-1:0] ph_nxt;
   logic [CNT_W-1:0] ph_inc;
   logic [CNT_W-1:0] cnt_nxt;
   logic [CNT_W-1:0] base;
   logic             past_base;
   logic             at_base;
   logic             unit_period;
   logic             phase_match;

   assign base        = start + offset;
   assign cnt_nxt     = cnt_q + 1'b1;
   assign at_base     = (cnt_nxt == base);
   assign past_base   = (cnt_nxt > base);
   assign unit_period = (period == {{(CNT_W-1){1'b0}}, 1'b1});
   assign ph_inc      = ph_q + 1'b1;

   always_comb begin
      if (at_base)
         ph_nxt = '0;
      else if (past_base)
         ph_nxt = (ph_inc >= period) ? '0 : ph_inc;
      else
         ph_nxt = ph_q;
   end

   // period 1: every count at or past base; otherwise one step past base
   assign phase_match = unit_period ? (ph_nxt == '0)
                                    : (ph_nxt == {{(CNT_W-1){1'b0}}, 1'b1});

   assign hit = retire & en & (period != '0) & (at_base | past_base) & phase_match;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ph_q  <= '0;
      end else if (retire) begin
         cnt_q <= cnt_nxt;
         ph_q  <= ph_nxt;
      end
   end

   assign cnt = cnt_q;

endmodule

// File: rtl/tie_gate.sv
// Mask decision for the scheduled request.
module tie_gate
   import tie_pkg::*;
#(
   parameter int            STAT_W     = 32,
   parameter int            MODE_W     = 5,
   parameter int            MASK_N_BIT = 7,
   parameter int            MASK_F_BIT = 6,
   parameter logic [MODE_W-1:0] FAST_MODE = 5'h11
) (
   input  logic              hit,
   input  tie_kind_e         kind,
   input  logic [STAT_W-1:0] status,
   output logic              take_now
);

   logic masked;
   logic in_fast_mode;

   assign in_fast_mode = (status[MODE_W-1:0] == FAST_MODE);

   always_comb begin
      if (kind == KIND_FAST)
         masked = status[MASK_F_BIT];
      else
         masked = status[MASK_N_BIT] | in_fast_mode;
   end

   assign take_now = hit & ~masked;

endmodule

// File: rtl/tie_build.sv
// Builds the entry values and registers them with the take pulse.
module tie_build
   import tie_pkg::*;
#(
   parameter int                STAT_W     = 32,
   parameter int                ADDR_W     = 32,
   parameter int                MODE_W     = 5,
   parameter int                MASK_N_BIT = 7,
   parameter int                MASK_F_BIT = 6,
   parameter logic [MODE_W-1:0] FAST_MODE  = 5'h11,
   parameter logic [MODE_W-1:0] NORM_MODE  = 5'h12,
   parameter logic [ADDR_W-1:0] VEC_FAST   = 'h1C,
   parameter logic [ADDR_W-1:0] VEC_NORM   = 'h18,
   parameter logic [ADDR_W-1:0] PREFETCH   = 'h8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take_now,
   input  tie_kind_e         kind,
   input  logic [STAT_W-1:0] status,
   input  logic [ADDR_W-1:0] pc,
   output logic              take,
   output logic [STAT_W-1:0] new_status,
   output logic [STAT_W-1:0] saved_status,
   output logic [ADDR_W-1:0] link_val,
   output logic [ADDR_W-1:0] vector_pc
);

   localparam logic [ADDR_W-1:0] LINK_BACK = 'h4;
   localparam logic [ADDR_W-1:0] ENTRY_F   = VEC_FAST + PREFETCH;
   localparam logic [ADDR_W-1:0] ENTRY_N   = VEC_NORM + PREFETCH;

   logic              is_fast;
   logic [STAT_W-1:0] built;

   assign is_fast = (kind == KIND_FAST);

   // per-bit construction of the status word to install
   for (genvar gi = 0; gi < STAT_W; gi++) begin : g_bit
      if (gi < MODE_W) begin : g_mode
         assign built[gi] = is_fast ? FAST_MODE[gi] : NORM_MODE[gi];
      end else if (gi == MASK_N_BIT) begin : g_nmask
         assign built[gi] = 1'b1;
      end else if (gi == MASK_F_BIT) begin : g_fmask
         assign built[gi] = status[gi] | is_fast;
      end else begin : g_keep
         assign built[gi] = status[gi];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         take         <= 1'b0;
         new_status   <= '0;
         saved_status <= '0;
         link_val     <= '0;
         vector_pc    <= '0;
      end else begin
         take <= take_now;
         if (take_now) begin
            new_status   <= built;
            saved_status <= status;
            link_val     <= pc - LINK_BACK;
            vector_pc    <= is_fast ? ENTRY_F : ENTRY_N;
         end
      end
   end

endmodule

// File: rtl/tick_irq_entry.sv
module tick_irq_entry
   import tie_pkg::*;
#(
   parameter int                CNT_W      = 32,
   parameter int                STAT_W     = 32,
   parameter int                ADDR_W     = 32,
   parameter int                MODE_W     = 5,
   parameter int                MASK_N_BIT = 7,
   parameter int                MASK_F_BIT = 6,
   parameter logic [MODE_W-1:0] FAST_MODE  = 5'h11,
   parameter logic [MODE_W-1:0] NORM_MODE  = 5'h12,
   parameter logic [ADDR_W-1:0] VEC_FAST   = 'h1C,
   parameter logic [ADDR_W-1:0] VEC_NORM   = 'h18,
   parameter logic [ADDR_W-1:0] PREFETCH   = 'h8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              retire,
   input  logic              cfg_en,
   input  logic              cfg_fast,
   input  logic [CNT_W-1:0]  cfg_start,
   input  logic [CNT_W-1:0]  cfg_offset,
   input  logic [CNT_W-1:0]  cfg_period,
   input  logic [STAT_W-1:0] cur_status,
   input  logic [ADDR_W-1:0] cur_pc,
   output logic [CNT_W-1:0]  retired_cnt,
   output logic              take,
   output logic [STAT_W-1:0] new_status,
   output logic [STAT_W-1:0] saved_status,
   output logic [ADDR_W-1:0] link_val,
   output logic [ADDR_W-1:0] vector_pc
);

   // elaboration-time parameter checks
   if (MASK_N_BIT >= STAT_W || MASK_F_BIT >= STAT_W) begin : g_bad_mask_pos
      $error("mask bit position outside status word");
   end
   if (MASK_N_BIT == MASK_F_BIT) begin : g_bad_mask_same
      $error("the two mask bits must differ");
   end
   if (MASK_N_BIT < MODE_W || MASK_F_BIT < MODE_W) begin : g_bad_mask_mode
      $error("mask bits overlap the mode field");
   end
   if (FAST_MODE == NORM_MODE) begin : g_bad_modes
      $error("mode codes must differ");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("counter too narrow");
   end

   tie_kind_e kind;
   logic      hit;
   logic      take_now;

   assign kind = cfg_fast ? KIND_FAST : KIND_NORMAL;

   tie_sched #(.CNT_W(CNT_W)) u_sched (
      .clk    (clk),
      .rst_n  (rst_n),
      .retire (retire),
      .en     (cfg_en),
      .start  (cfg_start),
      .offset (cfg_offset),
      .period (cfg_period),
      .cnt    (retired_cnt),
      .hit    (hit)
   );

   tie_gate #(
      .STAT_W     (STAT_W),
      .MODE_W     (MODE_W),
      .MASK_N_BIT (MASK_N_BIT),
      .MASK_F_BIT (MASK_F_BIT),
      .FAST_MODE  (FAST_MODE)
   ) u_gate (
      .hit      (hit),
      .kind     (kind),
      .status   (cur_status),
      .take_now (take_now)
   );

   tie_build #(
      .STAT_W     (STAT_W),
      .ADDR_W     (ADDR_W),
      .MODE_W     (MODE_W),
      .MASK_N_BIT (MASK_N_BIT),
      .MASK_F_BIT (MASK_F_BIT),
      .FAST_MODE  (FAST_MODE),
      .NORM_MODE  (NORM_MODE),
      .VEC_FAST   (VEC_FAST),
      .VEC_NORM   (VEC_NORM),
      .PREFETCH   (PREFETCH)
   ) u_build (
      .clk          (clk),
      .rst_n        (rst_n),
      .take_now     (take_now),
      .kind         (kind),
      .status       (cur_status),
      .pc           (cur_pc),
      .take         (take),
      .new_status   (new_status),
      .saved_status (saved_status),
      .link_val     (link_val),
      .vector_pc    (vector_pc)
   );

endmodule

// File: rtl/tick_irq_entry_chk.sv
module tick_irq_entry_chk #(
   parameter int                CNT_W      = 32,
   parameter int                STAT_W     = 32,
   parameter int                ADDR_W     = 32,
   parameter int                MODE_W     = 5,
   parameter int                MASK_N_BIT = 7,
   parameter int                MASK_F_BIT = 6,
   parameter logic [MODE_W-1:0] FAST_MODE  = 5'h11,
   parameter logic [MODE_W-1:0] NORM_MODE  = 5'h12,
   parameter logic [ADDR_W-1:0] VEC_FAST   = 'h1C,
   parameter logic [ADDR_W-1:0] VEC_NORM   = 'h18,
   parameter logic [ADDR_W-1:0] PREFETCH   = 'h8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              retire,
   input logic              cfg_en,
   input logic              cfg_fast,
   input logic [CNT_W-1:0]  cfg_period,
   input logic [STAT_W-1:0] cur_status,
   input logic [ADDR_W-1:0] cur_pc,
   input logic [CNT_W-1:0]  retired_cnt,
   input logic              take,
   input logic [STAT_W-1:0] new_status,
   input logic [STAT_W-1:0] saved_status,
   input logic [ADDR_W-1:0] link_val,
   input logic [ADDR_W-1:0] vector_pc
);

   a_r1_count_up: assert property (@(posedge clk) disable iff (!rst_n)
      retire |=> retired_cnt == $past(retired_cnt) + 1'b1);

   a_r1_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !retire |=> $stable(retired_cnt));

   a_r3_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (retire && (!cfg_en || cfg_period == '0)) |=> !take);

   a_r4_fast_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (retire && cfg_fast && cur_status[MASK_F_BIT]) |=> !take);

   a_r5_norm_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (retire && !cfg_fast &&
       (cur_status[MASK_N_BIT] || cur_status[MODE_W-1:0] == FAST_MODE)) |=> !take);

   a_r7_saved: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> saved_status == $past(cur_status));

   a_r8_mode: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (new_status[MODE_W-1:0] == ($past(cfg_fast) ? FAST_MODE : NORM_MODE))
               && new_status[MASK_N_BIT]);

   a_r9_link: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> link_val == $past(cur_pc) - 'h4);

   a_r10_vector: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> vector_pc == ($past(cfg_fast) ? VEC_FAST : VEC_NORM) + PREFETCH);

   a_r11_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> $past(retire));

endmodule

bind tick_irq_entry tick_irq_entry_chk #(
   .CNT_W      (CNT_W),
   .STAT_W     (STAT_W),
   .ADDR_W     (ADDR_W),
   .MODE_W     (MODE_W),
   .MASK_N_BIT (MASK_N_BIT),
   .MASK_F_BIT (MASK_F_BIT),
   .FAST_MODE  (FAST_MODE),
   .NORM_MODE  (NORM_MODE),
   .VEC_FAST   (VEC_FAST),
   .VEC_NORM   (VEC_NORM),
   .PREFETCH   (PREFETCH)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .retire       (retire),
   .cfg_en       (cfg_en),
   .cfg_fast     (cfg_fast),
   .cfg_period   (cfg_period),
   .cur_status   (cur_status),
   .cur_pc       (cur_pc),
   .retired_cnt  (retired_cnt),
   .take         (take),
   .new_status   (new_status),
   .saved_status (saved_status),
   .link_val     (link_val),
   .vector_pc    (vector_pc)
);

// File: tb/tb_tick_irq_entry.sv
module tb_tick_irq_entry;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        retire = 1'b0;
   logic        cfg_en = 1'b0;
   logic        cfg_fast = 1'b0;
   logic [31:0] cfg_start = '0;
   logic [31:0] cfg_offset = '0;
   logic [31:0] cfg_period = '0;
   logic [31:0] cur_status = '0;
   logic [31:0] cur_pc = '0;
   logic [31:0] retired_cnt;
   logic        take;
   logic [31:0] new_status;
   logic [31:0] saved_status;
   logic [31:0] link_val;
   logic [31:0] vector_pc;

   int n_cmp = 0;
   int n_bad = 0;
   int n_taken = 0;
   logic [31:0] m_cnt = '0;

   always #4 clk = ~clk;   // 125 MHz

   tick_irq_entry dut (
      .clk(clk), .rst_n(rst_n), .retire(retire), .cfg_en(cfg_en),
      .cfg_fast(cfg_fast), .cfg_start(cfg_start), .cfg_offset(cfg_offset),
      .cfg_period(cfg_period), .cur_status(cur_status), .cur_pc(cur_pc),
      .retired_cnt(retired_cnt), .take(take), .new_status(new_status),
      .saved_status(saved_status), .link_val(link_val), .vector_pc(vector_pc)
   );

   function automatic bit exp_fire(input logic [31:0] c);
      logic [31:0] b;
      b = cfg_start + cfg_offset;
      if (!cfg_en || cfg_period == 0) return 1'b0;
      if (c < b) return 1'b0;
      if (c == b) return cfg_period == 1;
      return ((c - b - 1) % cfg_period) == 0;
   endfunction

   function automatic bit exp_masked(input bit fast, input logic [31:0] st);
      if (fast) return st[6];
      return st[7] || (st[4:0] == 5'h11);
   endfunction

   function automatic logic [31:0] exp_new(input bit fast, input logic [31:0] st);
      logic [31:0] r;
      r = st;
      r[4:0] = fast ? 5'h11 : 5'h12;
      r[7] = 1'b1;
      if (fast) r[6] = 1'b1;
      return r;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h (count %0d)", req, act, exp, m_cnt);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      retire = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      m_cnt = '0;
      @(negedge clk);
      chk("R1", retired_cnt, 32'd0);
      chk("R6", {31'd0, take}, 32'd0);
   endtask

   // drive one cycle at a negedge, check at the following negedge
   task automatic step(input bit r, input logic [31:0] st, input logic [31:0] pc);
      bit    fire, tk;
      string why;
      retire = r;
      cur_status = st;
      cur_pc = pc;
      fire = 1'b0;
      if (r) begin
         m_cnt = m_cnt + 1;
         fire = exp_fire(m_cnt);
      end
      tk = fire && !exp_masked(cfg_fast, st);
      if (!r) why = "R11";
      else if (!cfg_en || cfg_period == 0) why = "R3";
      else if (!fire) why = "R2";
      else if (cfg_fast && st[6]) why = "R4";
      else if (!cfg_fast && (st[7] || st[4:0] == 5'h11)) why = "R5";
      else why = "R6";
      @(negedge clk);
      retire = 1'b0;
      chk("R1", retired_cnt, m_cnt);
      chk(why, {31'd0, take}, {31'd0, tk});
      if (tk && take) begin
         n_taken++;
         chk("R7", saved_status, st);
         chk("R8", new_status, exp_new(cfg_fast, st));
         chk("R9", link_val, pc - 32'd4);
         chk("R10", vector_pc, cfg_fast ? 32'h24 : 32'h20);
      end
   endtask

   function automatic logic [31:0] rnd_status(input int mask_pct);
      logic [31:0] s;
      logic [4:0]  modes [5];
      modes = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h1F};
      s = $urandom;
      s[4:0] = modes[$urandom_range(0, 4)];
      s[6] = ($urandom_range(0, 99) < mask_pct);
      s[7] = ($urandom_range(0, 99) < mask_pct);
      return s;
   endfunction

   task automatic config_run(input bit en, input bit fast, input int st, input int off,
                             input int per);
      cfg_en = en; cfg_fast = fast;
      cfg_start = st; cfg_offset = off; cfg_period = per;
      do_reset();
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL R6 watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd20240611));

      // directed: fast, base 5, period 4, unmasked status, continuous retires
      config_run(1'b1, 1'b1, 3, 2, 4);
      for (int i = 0; i < 24; i++) step(1'b1, 32'h0000_0010, 32'h100 + 4 * i);

      // directed: period 1, base 0, normal, every retire fires (R2)
      config_run(1'b1, 1'b0, 0, 0, 1);
      for (int i = 0; i < 8; i++) step(1'b1, 32'hA000_0013, 32'h400 + 4 * i);

      // idle cycles with an unmasked status between retires (R11)
      for (int i = 0; i < 6; i++) step(1'b0, 32'h0000_0010, 32'h800);
      step(1'b1, 32'h0000_0010, 32'h900);

      // normal interrupt while in fast mode is held off (R5)
      step(1'b1, 32'h0000_0011, 32'h904);
      // normal mask set (R5)
      step(1'b1, 32'h0000_0090, 32'h908);

      // fast mask set (R4)
      config_run(1'b1, 1'b1, 0, 0, 1);
      step(1'b1, 32'h0000_0050, 32'h10);
      step(1'b1, 32'h0000_0012, 32'h14);

      // disabled and zero period (R3)
      config_run(1'b0, 1'b1, 0, 0, 1);
      for (int i = 0; i < 6; i++) step(1'b1, 32'h0, 32'h20);
      config_run(1'b1, 1'b0, 0, 0, 0);
      for (int i = 0; i < 6; i++) step(1'b1, 32'h0, 32'h20);

      // random segments
      for (int seg = 0; seg < 24; seg++) begin
         config_run($urandom_range(0, 9) != 0, $urandom_range(0, 1),
                    $urandom_range(0, 12), $urandom_range(0, 12), $urandom_range(0, 6));
         for (int i = 0; i < 300; i++)
            step($urandom_range(0, 3) != 0, rnd_status(30), {$urandom} & 32'hFFFF_FFFC);
      end

      if (n_taken == 0) begin
         n_bad++;
         $display("FAIL R6 actual=0 expected=nonzero taken entries");
      end
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule